// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Router

This block takes a set of level-sensitive interrupt sources and delivers them to a small group of processors. A source reaches a processor only if it passes both gates. The first gate is a global enable bit that all processors share. The second gate is a mask bit that each processor holds for itself. A routing field per source also picks which processors may receive it. Enable and mask state is never rewritten as a whole bitmap. Software writes a source number to a dedicated set or clear location, and the block flips only that one bit.

Access goes through a simple register bus with address, write data, a write strobe and combinational read data. A `cpu_id` input names the processor making each access, and per-processor locations act on that processor's own copy. Each processor has one interrupt line out. Each processor can also read an acknowledge location that returns the lowest-numbered source it is eligible to take. By convention, the low source numbers up to 28 are per-processor sources: software enables them globally once and then gates them with the per-processor mask. Higher numbers are shared sources that software gates with the global enable. Sources 0 and 1 carry the summaries of the inter-processor and message-signalled doorbells, which come from a neighbouring block.

Top module: `mpirq_ctrl`

## Requirements
- R1: A read of address 0x000 returns the number of implemented sources in bits [11:2], with all other bits zero.
- R2: After reset every global enable is clear, every per-processor mask is set, and every routing field is zero. In this state no interrupt line is raised and every acknowledge read returns 1023, even if all source inputs are high.
- R3: Writing a source number n to 0x030 sets the global enable of source n. Writing it to 0x034 clears that enable. No other source's enable changes.
- R4: Writing n to 0x048 masks source n for the processor named by `cpu_id`. Writing n to 0x04C unmasks it. The mask copies of other processors do not change.
- R5: The source control register of source n is at 0x100 + 4*n. A write there stores bits [NUM_CPUS-1:0] as the routing field, one bit per processor with bit c for processor c. The other written bits are dropped.
- R6: A read of a source control register returns the routing field in bits [NUM_CPUS-1:0]. Bit 8+c reads 1 exactly when the routing bit c is set and source n is unmasked for processor c.
- R7: Processor c is eligible for source n when input n is high, its global enable is set, it is unmasked for c and routing bit c is set. A read of 0x044 returns, in bits [9:0], the lowest eligible source number for the reading processor, or 1023 when none is eligible.
- R8: Sources are level-sensitive. When an input drops, the source stops being eligible, and no latched state holds it.
- R9: A write to 0x030, 0x034, 0x048 or 0x04C is ignored when the written value is not below the number of sources, including when any bit above bit 9 is set.
- R10: Reads have no side effect. Repeated acknowledge reads return the same number while the inputs and the configuration are unchanged.
- R11: The interrupt line of processor c is a register. It is high one clock after any source is eligible for c, and low one clock after none is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| cpu_id | input | CPU_W | Processor making the access |
| bus_rdata | output | 32 | Combinational read data for bus_addr and cpu_id |
| src_i | input | NUM_SRC | Level-sensitive source inputs |
| irq_o | output | NUM_CPUS | Registered interrupt line per processor |

## Verification
The bench builds the block with its default parameters, two processors and 32 sources. With two processors, it can show that a mask write from one processor leaves the other's copy untouched. It can also show that a one-hot routing value steers a source to one side only. With 32 sources, the bench reaches both ends of the priority order, source 0 and source 31. It also reaches source number 40, a value that would alias to source 8 if the number were cut to five bits. The bench uses that case to show that an out-of-range write is dropped and not folded onto a real source.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;

  localparam int SRCNUM_W    = 10;
  localparam int CTL_FIQ_LSB = 8;
  localparam logic [SRCNUM_W-1:0] NO_SRC = '1;

  localparam int OFS_INFO     = 'h000;
  localparam int OFS_EN_SET   = 'h030;
  localparam int OFS_EN_CLR   = 'h034;
  localparam int OFS_ACK      = 'h044;
  localparam int OFS_MSK_SET  = 'h048;
  localparam int OFS_MSK_CLR  = 'h04C;
  localparam int OFS_SRC_BASE = 'h100;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EN_SET,
    OP_EN_CLR,
    OP_MSK_SET,
    OP_MSK_CLR,
    OP_ROUTE
  } op_e;

endpackage

// File: rtl/mpirq_gate.sv
module mpirq_gate
  import mpirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  op_e                op,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] en_q
);

  logic [NUM_SRC-1:0] en_d;
  logic               en_ce;

  always_comb begin
    en_d  = en_q;
    en_ce = 1'b0;
    if (op == OP_EN_SET) begin
      en_d[idx] = 1'b1;
      en_ce     = 1'b1;
    end else if (op == OP_EN_CLR) begin
      en_d[idx] = 1'b0;
      en_ce     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // R3: set and clear act on the addressed source
  a_r3_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EN_SET) |=> en_q[$past(idx)]);
  a_r3_clr_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EN_CLR) |=> !en_q[$past(idx)]);
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_EN_SET && op != OP_EN_CLR) |=> $stable(en_q));

endmodule

// File: rtl/mpirq_mask.sv
module mpirq_mask
  import mpirq_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRC  = 32,
  parameter int IDX_W    = 5,
  parameter int CPU_W    = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  op_e                               op,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [CPU_W-1:0]                  cpu,
  output logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q
);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRC-1:0] row_d;
    logic               row_ce;

    always_comb begin
      row_d  = mask_q[c];
      row_ce = 1'b0;
      if (cpu == CPU_W'(c)) begin
        if (op == OP_MSK_SET) begin
          row_d[idx] = 1'b1;
          row_ce     = 1'b1;
        end else if (op == OP_MSK_CLR) begin
          row_d[idx] = 1'b0;
          row_ce     = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q[c] <= '1;
      else if (row_ce) mask_q[c] <= row_d;
    end

    // R4: only the accessing processor's copy moves
    a_r4_other_cpu_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu != CPU_W'(c)) |=> $stable(mask_q[c]));
    a_r4_unmask_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MSK_CLR && cpu == CPU_W'(c)) |=> !mask_q[c][$past(idx)]);
  end

endmodule

// File: rtl/mpirq_route.sv
module mpirq_route
  import mpirq_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRC  = 32,
  parameter int IDX_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  op_e                               op,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [NUM_CPUS-1:0]               data,
  output logic [NUM_SRC-1:0][NUM_CPUS-1:0]  route_q
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic               ce;
    logic [NUM_CPUS-1:0] nxt;

    always_comb begin
      ce  = (op == OP_ROUTE) && (idx == IDX_W'(s));
      nxt = ce ? data : route_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  route_q[s] <= '0;
      else if (ce) route_q[s] <= nxt;
    end
  end

  // R5: routing field takes the written low bits
  a_r5_route_store: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROUTE) |=> (route_q[$past(idx)] == $past(data)));

endmodule

// File: rtl/mpirq_pick.sv
module mpirq_pick
  import mpirq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]  elig,
  output logic [SRCNUM_W-1:0] num
);

  always_comb begin
    num = NO_SRC;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) num = SRCNUM_W'(i);
    end
  end

endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
  import mpirq_pkg::*;
#(
  parameter  int NUM_CPUS = 2,
  parameter  int NUM_SRC  = 32,
  parameter  int ADDR_W   = 12,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  input  logic [CPU_W-1:0]    cpu_id,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic [NUM_CPUS-1:0] irq_o
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [SRCNUM_W-1:0] NSRC_L  = SRCNUM_W'(NUM_SRC);
  localparam logic [ADDR_W-3:0]   WIN_L   = (ADDR_W-2)'(NUM_SRC);
  localparam logic [CPU_W:0]      NCPU_L  = (CPU_W+1)'(NUM_CPUS);
  localparam logic [ADDR_W-1:0]   A_INFO  = ADDR_W'(OFS_INFO);
  localparam logic [ADDR_W-1:0]   A_ENS   = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0]   A_ENC   = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0]   A_ACK   = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0]   A_MSS   = ADDR_W'(OFS_MSK_SET);
  localparam logic [ADDR_W-1:0]   A_MSC   = ADDR_W'(OFS_MSK_CLR);
  localparam logic [ADDR_W-1:0]   A_BASE  = ADDR_W'(OFS_SRC_BASE);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // decode
  logic [SRCNUM_W-1:0] wr_num;
  logic                num_ok;
  logic [ADDR_W-1:0]   win_off;
  logic                in_win;
  logic [IDX_W-1:0]    win_idx;
  logic                cpu_ok;
  op_e                 op;
  logic [IDX_W-1:0]    tgt_idx;

  always_comb begin
    wr_num  = bus_wdata[SRCNUM_W-1:0];
    num_ok  = (bus_wdata[31:SRCNUM_W] == '0) && (wr_num < NSRC_L);
    win_off = bus_addr - A_BASE;
    in_win  = (bus_addr >= A_BASE) && (win_off[ADDR_W-1:2] < WIN_L) &&
              (win_off[1:0] == 2'b00);
    win_idx = win_off[IDX_W+1:2];
    cpu_ok  = ({1'b0, cpu_id} < NCPU_L);
    op      = OP_NONE;
    tgt_idx = wr_num[IDX_W-1:0];
    if (bus_we) begin
      if (in_win) begin
        op      = OP_ROUTE;
        tgt_idx = win_idx;
      end else if (num_ok) begin
        case (bus_addr)
          A_ENS:   op = OP_EN_SET;
          A_ENC:   op = OP_EN_CLR;
          A_MSS:   op = cpu_ok ? OP_MSK_SET : OP_NONE;
          A_MSC:   op = cpu_ok ? OP_MSK_CLR : OP_NONE;
          default: op = OP_NONE;
        endcase
      end
    end
  end

  // state banks
  logic [NUM_SRC-1:0]                en_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0]  route_q;

  mpirq_gate #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(tgt_idx), .en_q(en_q)
  );

  mpirq_mask #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W),
               .CPU_W(CPU_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(tgt_idx), .cpu(cpu_id),
    .mask_q(mask_q)
  );

  mpirq_route #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(tgt_idx),
    .data(bus_wdata[NUM_CPUS-1:0]), .route_q(route_q)
  );

  // per-processor eligibility, priority pick and output line
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]  route_col;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]  elig;
  logic [NUM_CPUS-1:0][SRCNUM_W-1:0] ack_num;
  logic [NUM_CPUS-1:0]               irq_d;
  logic [NUM_CPUS-1:0]               irq_q;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign route_col[c][s] = route_q[s][c];
    end

    assign elig[c]  = src_i & en_q & ~mask_q[c] & route_col[c];
    assign irq_d[c] = |elig[c];

    mpirq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .elig(elig[c]), .num(ack_num[c])
    );

    // R7: acknowledge number is the lowest eligible source, or none
    a_r7_ack_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_num[c] != NO_SRC) |->
        ((((elig[c] >> ack_num[c]) & {{(NUM_SRC-1){1'b0}}, 1'b1}) != '0) &&
         ((elig[c] & ~({NUM_SRC{1'b1}} << ack_num[c])) == '0)));
    a_r7_ack_none: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_num[c] == NO_SRC) |-> (elig[c] == '0));
    // R11: line follows eligibility one clock later
    a_r11_line_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_num[c] != NO_SRC) |=> irq_o[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_INFO) begin
      bus_rdata[SRCNUM_W+1:2] = NSRC_L;
    end else if (bus_addr == A_ACK) begin
      bus_rdata[SRCNUM_W-1:0] = cpu_ok ? ack_num[cpu_id] : NO_SRC;
    end else if (in_win) begin
      bus_rdata[NUM_CPUS-1:0] = route_q[win_idx];
      for (int c = 0; c < NUM_CPUS; c++) begin
        bus_rdata[CTL_FIQ_LSB+c] = route_q[win_idx][c] & ~mask_q[c][win_idx];
      end
    end
  end

  // R8: with every input low no line is raised
  a_r8_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> (irq_o == '0));
  // R9: out-of-range enable writes leave the enables alone
  a_r9_bad_num_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_ENS || bus_addr == A_ENC) && !num_ok)
      |=> $stable(en_q));

endmodule

// File: tb/mpirq_ctrl_bench.sv
module mpirq_ctrl_bench;

  localparam int NCPU = 2;
  localparam int NSRC = 32;
  localparam int AW   = 12;
  localparam int HALF = 10;

  logic            clk;
  logic            arst_n;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic            bus_we;
  logic [0:0]      cpu_id;
  logic [31:0]     bus_rdata;
  logic [NSRC-1:0] src_i;
  logic [NCPU-1:0] irq_o;

  mpirq_ctrl #(.NUM_CPUS(NCPU), .NUM_SRC(NSRC), .ADDR_W(AW)) u_mpirq_ctrl (
    .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .cpu_id(cpu_id), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // scoreboard
  string       tag_q[$];
  logic [31:0] exp_q[$];
  bit          kind_q[$];
  logic        obs_stb;

  always @(negedge clk) begin
    if (obs_stb) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: got observation 0x%0h expected a queued item", bus_rdata);
      end else begin
        string       t;
        logic [31:0] e;
        logic [31:0] a;
        bit          k;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        a = k ? {{(32-NCPU){1'b0}}, irq_o} : bus_rdata;
        n_chk++;
        if (a !== e) begin
          n_err++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", t, a, e);
        end
      end
    end
  end

  function automatic logic [AW-1:0] ctl_addr(input int n);
    return AW'('h100 + 4 * n);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int cpu);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; cpu_id = cpu[0:0]; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input int cpu,
                        input logic [31:0] e, input string t);
    bus_addr = a; cpu_id = cpu[0:0];
    tag_q.push_back(t); exp_q.push_back(e); kind_q.push_back(1'b0);
    obs_stb = 1'b1;
    @(posedge clk); #2;
    obs_stb = 1'b0;
  endtask

  task automatic chk_irq_now(input logic [NCPU-1:0] e, input string t);
    tag_q.push_back(t); exp_q.push_back({{(32-NCPU){1'b0}}, e}); kind_q.push_back(1'b1);
    obs_stb = 1'b1;
    @(posedge clk); #2;
    obs_stb = 1'b0;
  endtask

  task automatic chk_irq(input logic [NCPU-1:0] e, input string t);
    @(posedge clk); #2;
    chk_irq_now(e, t);
  endtask

  task automatic set_src(input int n, input logic v);
    @(posedge clk); #2;
    src_i[n] = v;
  endtask

  initial begin
    #(2 * HALF * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    arst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    cpu_id = '0; src_i = '1; obs_stb = 1'b0;
    repeat (4) @(posedge clk);
    #2 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1 and R2
    chk_rd(12'h000, 0, 32'd128, "R1 info register");
    chk_rd(12'h044, 0, 32'd1023, "R2 reset ack cpu0");
    chk_rd(12'h044, 1, 32'd1023, "R2 reset ack cpu1");
    chk_rd(ctl_addr(31), 0, 32'h0, "R2 reset source control");
    chk_irq(2'b00, "R2 reset lines with all inputs high");
    src_i = '0;

    // R3: shared source 30 through the global gate
    wr(ctl_addr(30), 32'h1, 0);
    wr(12'h04C, 32'd30, 0);
    set_src(30, 1'b1);
    chk_irq(2'b00, "R3 not yet enabled");
    wr(12'h030, 32'd30, 0);
    chk_irq(2'b01, "R3 enabled");
    chk_rd(12'h044, 0, 32'd30, "R3 ack cpu0");
    wr(12'h034, 32'd30, 1);
    chk_irq(2'b00, "R3 cleared");

    // R4: per-processor masks
    wr(12'h030, 32'd30, 0);
    wr(ctl_addr(30), 32'h3, 0);
    chk_irq(2'b01, "R4 cpu1 still masked");
    wr(12'h04C, 32'd30, 1);
    chk_irq(2'b11, "R4 cpu1 unmasked");
    wr(12'h048, 32'd30, 0);
    chk_irq(2'b10, "R4 cpu0 masked, cpu1 kept");
    chk_rd(12'h044, 0, 32'd1023, "R4 ack cpu0");
    chk_rd(12'h044, 1, 32'd30, "R4 ack cpu1");

    // R5 and R6: routing field and read-only unmask view
    wr(ctl_addr(30), 32'hFFFF_FFFE, 0);
    chk_rd(ctl_addr(30), 0, 32'h0000_0202, "R5 upper bits dropped, R6 view");
    chk_irq(2'b10, "R5 steered to cpu1");
    wr(12'h04C, 32'd30, 0);
    chk_rd(ctl_addr(30), 1, 32'h0000_0202, "R6 unmask without route");
    wr(ctl_addr(30), 32'h1, 0);
    chk_rd(ctl_addr(30), 0, 32'h0000_0101, "R6 route cpu0 only");
    chk_irq(2'b01, "R5 steered to cpu0");

    // R7: lowest eligible wins, both ends of the range
    for (int k = 0; k < 4; k++) begin
      int n;
      n = (k == 0) ? 3 : (k == 1) ? 17 : (k == 2) ? 31 : 0;
      wr(12'h030, 32'(n), 1);
      wr(ctl_addr(n), 32'h2, 1);
      wr(12'h04C, 32'(n), 1);
    end
    set_src(31, 1'b1);
    set_src(17, 1'b1);
    chk_rd(12'h044, 1, 32'd17, "R7 lowest of 17 and 31");
    set_src(3, 1'b1);
    chk_rd(12'h044, 1, 32'd3, "R7 lowest of 3, 17, 31");
    chk_rd(12'h044, 0, 32'd30, "R7 cpu0 sees only its own");
    set_src(0, 1'b1);
    chk_rd(12'h044, 1, 32'd0, "R7 source 0 wins");
    chk_rd(12'h044, 1, 32'd0, "R10 repeated ack read");
    chk_irq(2'b11, "R7 both lines");

    // R8: level sensitivity
    set_src(0, 1'b0);
    chk_rd(12'h044, 1, 32'd3, "R8 source 0 dropped");
    set_src(3, 1'b0);
    chk_rd(12'h044, 1, 32'd17, "R8 source 3 dropped");
    src_i = '0;
    chk_rd(12'h044, 0, 32'd1023, "R8 all dropped cpu0");
    chk_rd(12'h044, 1, 32'd1023, "R8 all dropped cpu1");
    chk_irq(2'b00, "R8 lines low");

    // R9: out-of-range numbers must not alias onto source 8
    wr(ctl_addr(8), 32'h1, 0);
    wr(12'h04C, 32'd8, 0);
    set_src(8, 1'b1);
    wr(12'h030, 32'd40, 0);
    chk_irq(2'b00, "R9 set-enable 40 ignored");
    chk_rd(12'h044, 0, 32'd1023, "R9 ack after ignored write");
    wr(12'h030, 32'd8, 0);
    chk_irq(2'b01, "R9 real source 8 enabled");
    wr(12'h034, 32'h0000_0408, 0);
    chk_irq(2'b01, "R9 clear with high bits ignored");
    wr(12'h048, 32'd40, 0);
    chk_rd(12'h044, 0, 32'd8, "R9 mask 40 ignored");

    // R11: one clock from input to line
    set_src(8, 1'b0);
    chk_irq_now(2'b01, "R11 line before register update");
    chk_irq_now(2'b00, "R11 line after one clock");
    set_src(8, 1'b1);
    chk_irq_now(2'b00, "R11 rise before register update");
    chk_irq_now(2'b01, "R11 rise after one clock");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard: got %0d pending items expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule